// File: doc/BRIEF.md
# Flash Erase and Protection Controller

This block guards a 32 KB flash store, held here as an internal word array, and sits between requesters and that store. Each request is a read, a word program or a block erase. Each carries a tag that says who issues it: an instruction fetch, a data access or a debugger. The request's address selects one of sixteen 2 KB protection regions. The two attribute bits of that region decide whether the request goes ahead. A request that is refused leaves the store untouched and raises a sticky violation flag. A refused read returns zeros.

Erase works at 1 KB granularity: half of a protection region. The erase sequencer then rewrites every word of the chosen block to all ones, one word per cycle. While it does so, a busy flag is high and the request port stalls. Programming can only clear bits, so a programmed word becomes the AND of its old contents and the written value. Software loads the attribute bits through a small configuration port.

Top module: `flash_guard`

## Requirements
- R1: A read accepted while `req_ready` is high returns the stored 64-bit word on `rd_data`, with `rd_valid` high, in the next cycle. Word address `req_addr` counts 8-byte words.
- R2: An accepted program (`req_op` = 01) replaces the word with the bitwise AND of its old value and `req_wdata`. No bit can go from 0 to 1.
- R3: An accepted erase (`req_op` = 10) sets all 128 words of the 1 KB block `req_addr[11:7]` to all ones. Words outside that block are not changed.
- R4: After an accepted erase, `busy` is high for exactly 128 cycles and `req_ready` is low for that period. A request held during that time is stalled and is carried out only after the erase has finished.
- R5: A region with the read-only bit set refuses program and erase. It still serves reads from every source.
- R6: A region with the execute-only bit set refuses program and erase. It also refuses reads tagged data (`req_src` = 01) or debugger (10, with 11 treated the same). It serves reads tagged instruction fetch (00).
- R7: A refused read returns all zeros with `rd_valid` high in the next cycle.
- R8: A refused request leaves the array unchanged and sets `fault` in the next cycle. `fault` stays set until `fault_clr` is pulsed. When a new refusal and a clear fall in the same cycle, the refusal wins.
- R9: Protection is looked up per 2 KB region, `req_addr[11:8]`. Both 1 KB blocks of a region follow its attributes, and neighbouring regions are unaffected.
- R10: After reset, `busy`, `fault` and `rd_valid` are low, `req_ready` is high, and every region is unprotected.
- R11: The reserved operation code 11 is ignored. It produces no read response, does not change the array and does not set `fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 00 read, 01 program, 10 erase, 11 reserved |
| req_src | input | 2 | 00 instruction fetch, 01 data, 10/11 debugger |
| req_addr | input | 12 | Word address (64-bit words) |
| req_wdata | input | 64 | Program data |
| req_ready | output | 1 | Request accepted this cycle when high |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 64 | Read response data, zero when refused |
| busy | output | 1 | Erase in progress |
| fault | output | 1 | Sticky access violation |
| fault_clr | input | 1 | Clears `fault` |
| prot_we | input | 1 | Load attribute bits of one region |
| prot_rgn | input | 4 | Region to load |
| prot_ro | input | 1 | Read-only attribute value |
| prot_xo | input | 1 | Execute-only attribute value |

## Verification
A wrong attribute bit or a bad region decode shows up at the very next cycle. The symptom is a `fault` edge where none was due, or a zeroed `rd_data`, or a missing one of either. A fault in the erase counter shows as a `busy` pulse of the wrong length, and later as a block whose edge words read back unerased. A wrong program path shows only when the word is read back. The bench therefore reads every word it has touched in random order against its own model of the array.

// File: rtl/flash_guard_pkg.sv
// Shared encodings for the flash guard.
// Assumes two-bit operation and source fields at the request port.
package flash_guard_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_PROG  = 2'b01,
        OP_ERASE = 2'b10,
        OP_NONE  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        SRC_FETCH = 2'b00,
        SRC_DATA  = 2'b01,
        SRC_DEBUG = 2'b10,
        SRC_OTHER = 2'b11
    } src_e;

    typedef struct packed {
        logic ro;
        logic xo;
    } attr_t;
endpackage

// File: rtl/flash_prot_table.sv
// Holds the attribute bits for each protection region and decides, with no
// clock delay, whether a request may proceed.
// Assumes software loads at most one region per cycle.
module flash_prot_table
    import flash_guard_pkg::*;
#(
    parameter int REGIONS = 16,
    parameter int RGN_W   = $clog2(REGIONS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [RGN_W-1:0] cfg_rgn,
    input  logic             cfg_ro,
    input  logic             cfg_xo,
    input  logic [RGN_W-1:0] chk_rgn,
    input  op_e              chk_op,
    input  src_e             chk_src,
    output logic             allow
);
    attr_t attr_q [REGIONS];
    attr_t cur;
    logic  is_write;

    for (genvar g = 0; g < REGIONS; g++) begin : g_rgn
        // Attribute register of one region, cleared at reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                attr_q[g] <= '0;
            else if (cfg_we && cfg_rgn == RGN_W'(g))
                attr_q[g] <= '{ro: cfg_ro, xo: cfg_xo};
        end
    end

    // Permission decision for the presented request.
    always_comb begin
        cur      = attr_q[chk_rgn];
        is_write = (chk_op == OP_PROG) || (chk_op == OP_ERASE);
        allow    = !((is_write && (cur.ro || cur.xo)) ||
                     (chk_op == OP_READ && cur.xo && chk_src != SRC_FETCH));
    end
endmodule

// File: rtl/flash_erase_seq.sv
// Walks one erase block word by word, issuing one all-ones write per cycle.
// Assumes start is only raised while not busy.
module flash_erase_seq #(
    parameter int ADDR_W = 12,
    parameter int BLK_W  = 7,
    localparam int IDX_W = ADDR_W - BLK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  start_blk,
    output logic              busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr
);
    localparam logic [BLK_W-1:0] LAST = '1;

    logic [BLK_W-1:0] cnt;
    logic [IDX_W-1:0] blk;

    // Busy flag, block latch and word counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            blk  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
            blk  <= start_blk;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST)
                busy <= 1'b0;
        end
    end

    // Write strobe and address for the current erase word.
    always_comb begin
        wr_en   = busy;
        wr_addr = {blk, cnt};
    end

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);                                    // R4
    AST_ERASE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt == LAST) |=> !busy);                                // R4
endmodule

// File: rtl/flash_array.sv
// Word-wide storage with a registered read port, an AND-style program port
// and an erase port. Contents are not reset.
// Assumes the program and erase ports are never active together.
module flash_array #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 64,
    localparam int WORDS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              ers_en,
    input  logic [ADDR_W-1:0] ers_addr,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_q
);
    logic [DATA_W-1:0] mem [WORDS];

    // Storage update: erase writes ones, program can only clear bits.
    always_ff @(posedge clk) begin
        if (ers_en)
            mem[ers_addr] <= '1;
        else if (prog_en)
            mem[prog_addr] <= mem[prog_addr] & prog_data;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (rd_en)
            rd_q <= mem[rd_addr];
    end

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_en && ers_en));                                           // R4
endmodule

// File: rtl/flash_guard.sv
// Top of the flash guard: accepts requests, checks them against the region
// attributes, drives the array and erase sequencer, and keeps the fault flag.
// Assumes req_* are stable while req_valid is high and req_ready is low.
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int ARRAY_BYTES = 32768,
    parameter int DATA_W      = 64,
    parameter int ERASE_BYTES = 1024,
    parameter int PROT_BYTES  = 2048,
    parameter int ADDR_W      = $clog2(ARRAY_BYTES / (DATA_W / 8)),
    parameter int RGN_W       = $clog2(ARRAY_BYTES / PROT_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [1:0]        req_src,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              fault,
    input  logic              fault_clr,
    input  logic              prot_we,
    input  logic [RGN_W-1:0]  prot_rgn,
    input  logic              prot_ro,
    input  logic              prot_xo
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int BLK_W      = $clog2(ERASE_BYTES / WORD_BYTES);
    localparam int REGIONS    = ARRAY_BYTES / PROT_BYTES;

    op_e               op;
    src_e              src;
    logic              acc, allow, reject;
    logic              rd_en, prog_en, ers_start;
    logic              ers_wr;
    logic [ADDR_W-1:0] ers_addr;
    logic [DATA_W-1:0] rd_q;
    logic              rd_rej;

    // Request decode and gating by the permission result.
    always_comb begin
        op        = op_e'(req_op);
        src       = src_e'(req_src);
        req_ready = !busy;
        acc       = req_valid && req_ready;
        rd_en     = acc && op == OP_READ  && allow;
        prog_en   = acc && op == OP_PROG  && allow;
        ers_start = acc && op == OP_ERASE && allow;
        reject    = acc && op != OP_NONE  && !allow;
    end

    flash_prot_table #(.REGIONS(REGIONS), .RGN_W(RGN_W)) u_prot (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (prot_we),
        .cfg_rgn (prot_rgn),
        .cfg_ro  (prot_ro),
        .cfg_xo  (prot_xo),
        .chk_rgn (req_addr[ADDR_W-1 -: RGN_W]),
        .chk_op  (op),
        .chk_src (src),
        .allow   (allow)
    );

    flash_erase_seq #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (ers_start),
        .start_blk (req_addr[ADDR_W-1:BLK_W]),
        .busy      (busy),
        .wr_en     (ers_wr),
        .wr_addr   (ers_addr)
    );

    flash_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en   (prog_en),
        .prog_addr (req_addr),
        .prog_data (req_wdata),
        .ers_en    (ers_wr),
        .ers_addr  (ers_addr),
        .rd_en     (rd_en),
        .rd_addr   (req_addr),
        .rd_q      (rd_q)
    );

    // Read response flags and the sticky violation flag; a refusal beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_rej   <= 1'b0;
            fault    <= 1'b0;
        end else begin
            rd_valid <= acc && op == OP_READ;
            rd_rej   <= acc && op == OP_READ && !allow;
            if (reject)
                fault <= 1'b1;
            else if (fault_clr)
                fault <= 1'b0;
        end
    end

    // Refused reads return zeros.
    always_comb rd_data = rd_rej ? '0 : rd_q;

    AST_FAULT_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op != OP_NONE && !allow) |=> fault);                     // R8
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !fault_clr) |=> fault);                                // R8
    AST_REJECT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op == OP_READ && !allow) |=> (rd_valid && rd_data == '0)); // R7
    AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op == OP_NONE && !fault) |=> (!rd_valid && !fault));     // R11
endmodule

// File: tb/tb_flash_guard.sv
module tb_flash_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00, req_src = 2'b00;
    logic [11:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        req_ready, rd_valid, busy, fault;
    logic [63:0] rd_data;
    logic        fault_clr = 1'b0, prot_we = 1'b0, prot_ro = 1'b0, prot_xo = 1'b0;
    logic [3:0]  prot_rgn = '0;

    int nchk = 0, nerr = 0, cyc = 0;
    logic [63:0] model [4096];
    bit ro_m [16];
    bit xo_m [16];
    bit fault_exp = 0;

    flash_guard dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_src(req_src), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .fault(fault), .fault_clr(fault_clr), .prot_we(prot_we),
        .prot_rgn(prot_rgn), .prot_ro(prot_ro), .prot_xo(prot_xo)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            nerr++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    task automatic chk(bit c, string rq, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (!c) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    function automatic bit allowed(logic [1:0] o, logic [1:0] s, logic [11:0] a);
        int rg = int'(a[11:8]);
        if ((o == 2'b01 || o == 2'b10) && (ro_m[rg] || xo_m[rg])) return 0;
        if (o == 2'b00 && xo_m[rg] && s != 2'b00) return 0;
        return 1;
    endfunction

    task automatic set_prot(int rg, bit ro, bit xo);
        @(negedge clk);
        prot_we = 1; prot_rgn = 4'(rg); prot_ro = ro; prot_xo = xo;
        @(negedge clk);
        prot_we = 0;
        ro_m[rg] = ro; xo_m[rg] = xo;
    endtask

    task automatic clr_fault(string rq);
        @(negedge clk); fault_clr = 1;
        @(negedge clk); fault_clr = 0;
        fault_exp = 0;
        chk(fault === 1'b0, rq, 64'(fault), 64'd0);
    endtask

    task automatic do_op(logic [1:0] o, logic [1:0] s, logic [11:0] a,
                         logic [63:0] d, string rq);
        bit ok = allowed(o, s, a);
        int n = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_op = o; req_src = s; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        if (o == 2'b00) begin
            chk(rd_valid === 1'b1, rq, 64'(rd_valid), 64'd1);
            chk(rd_data === (ok ? model[a] : 64'd0), rq, rd_data, ok ? model[a] : 64'd0);
        end else begin
            chk(rd_valid === 1'b0, rq, 64'(rd_valid), 64'd0);
        end
        if (o != 2'b11 && !ok) fault_exp = 1;
        chk(fault === fault_exp, rq, 64'(fault), 64'(fault_exp));
        if (ok && o == 2'b01) model[a] = model[a] & d;
        if (ok && o == 2'b10) begin
            for (int i = 0; i < 128; i++) model[{a[11:7], 7'(i)}] = '1;
            while (busy === 1'b1) begin
                chk(req_ready === 1'b0, "R4", 64'(req_ready), 64'd0);
                n++;
                @(negedge clk);
            end
            chk(n == 128, "R4", 64'(n), 64'd128);
        end else begin
            chk(busy === 1'b0, rq, 64'(busy), 64'd0);
        end
    endtask

    initial begin
        int n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state
        chk(busy === 1'b0 && fault === 1'b0 && rd_valid === 1'b0 && req_ready === 1'b1,
            "R10", {busy, fault, rd_valid, req_ready}, 4'b0001);

        // R3: erase every block (all regions unprotected after reset, R10)
        for (int b = 0; b < 32; b++) do_op(2'b10, 2'b01, 12'(b << 7), '0, "R10");
        do_op(2'b00, 2'b01, 12'h000, '0, "R3");
        do_op(2'b00, 2'b10, 12'hFFF, '0, "R3");

        // R2: program can only clear bits
        do_op(2'b01, 2'b01, 12'h005, 64'hF0F0_F0F0_FFFF_0000, "R2");
        do_op(2'b01, 2'b01, 12'h005, 64'h0FF0_0FF0_00FF_FFFF, "R2");
        do_op(2'b00, 2'b01, 12'h005, '0, "R2");
        chk(rd_data === 64'h00F0_00F0_00FF_0000, "R2", rd_data, 64'h00F0_00F0_00FF_0000);

        // R3: block boundary, erase block 0 only
        do_op(2'b01, 2'b01, 12'h07F, 64'h1234, "R1");
        do_op(2'b01, 2'b01, 12'h080, 64'h5678, "R1");
        do_op(2'b10, 2'b00, 12'h010, '0, "R3");
        do_op(2'b00, 2'b01, 12'h07F, '0, "R3");
        do_op(2'b00, 2'b01, 12'h080, '0, "R3");
        chk(rd_data === 64'h5678, "R3", rd_data, 64'h5678);

        // R4: program held during erase is stalled, then applied after it
        @(negedge clk);
        req_valid = 1; req_op = 2'b10; req_src = 2'b01; req_addr = 12'h100;
        @(negedge clk);
        req_op = 2'b01; req_addr = 12'h101; req_wdata = 64'hA5;
        n = 0;
        while (!req_ready) begin n++; @(negedge clk); end
        chk(n == 128, "R4", 64'(n), 64'd128);
        @(negedge clk);
        req_valid = 0;
        for (int i = 0; i < 128; i++) model[12'h100 + 12'(i)] = '1;
        model[12'h101] = 64'hA5;
        do_op(2'b00, 2'b01, 12'h101, '0, "R4");

        // R5: read-only region 3
        do_op(2'b01, 2'b01, 12'h300, 64'h0F, "R5");
        set_prot(3, 1, 0);
        do_op(2'b01, 2'b01, 12'h300, 64'h00, "R5");
        do_op(2'b10, 2'b01, 12'h300, '0, "R5");
        do_op(2'b00, 2'b00, 12'h300, '0, "R5");
        do_op(2'b00, 2'b01, 12'h300, '0, "R5");
        do_op(2'b00, 2'b10, 12'h300, '0, "R8");
        chk(rd_data === 64'h0F, "R8", rd_data, 64'h0F);
        clr_fault("R8");

        // R6, R7: execute-only region 4
        do_op(2'b01, 2'b01, 12'h410, 64'h77, "R6");
        set_prot(4, 0, 1);
        do_op(2'b00, 2'b00, 12'h410, '0, "R6");
        chk(rd_data === 64'h77, "R6", rd_data, 64'h77);
        do_op(2'b00, 2'b01, 12'h410, '0, "R7");
        chk(rd_data === 64'd0, "R7", rd_data, 64'd0);
        do_op(2'b00, 2'b10, 12'h410, '0, "R7");
        do_op(2'b00, 2'b11, 12'h410, '0, "R6");
        do_op(2'b01, 2'b00, 12'h410, 64'h0, "R6");
        do_op(2'b10, 2'b00, 12'h410, '0, "R6");
        clr_fault("R6");

        // R9: both blocks of region 5 follow its attribute, region 6 is free
        set_prot(5, 1, 0);
        do_op(2'b01, 2'b01, 12'h500, 64'h0, "R9");
        clr_fault("R9");
        do_op(2'b01, 2'b01, 12'h5FF, 64'h0, "R9");
        clr_fault("R9");
        do_op(2'b01, 2'b01, 12'h600, 64'h3, "R9");
        do_op(2'b01, 2'b01, 12'h4FF, 64'h0, "R9");
        clr_fault("R9");

        // R8: refusal in the same cycle as a clear keeps the flag set
        @(negedge clk);
        req_valid = 1; req_op = 2'b01; req_addr = 12'h500; fault_clr = 1;
        @(negedge clk);
        req_valid = 0; fault_clr = 0;
        chk(fault === 1'b1, "R8", 64'(fault), 64'd1);
        @(negedge clk);
        chk(fault === 1'b1, "R8", 64'(fault), 64'd1);
        clr_fault("R8");

        // R11: reserved op changes nothing
        do_op(2'b11, 2'b01, 12'h300, 64'h0, "R11");
        do_op(2'b11, 2'b01, 12'h600, 64'h0, "R11");
        do_op(2'b00, 2'b01, 12'h600, '0, "R11");
        chk(rd_data === 64'h3, "R11", rd_data, 64'h3);

        // R1..R9: random traffic against the model
        for (int r = 0; r < 16; r++) set_prot(r, ($urandom % 4) == 0, ($urandom % 4) == 0);
        for (int k = 0; k < 400; k++) begin
            logic [1:0]  o = 2'($urandom % 4);
            logic [11:0] a = 12'($urandom);
            logic [63:0] d = {$urandom, $urandom} | {$urandom, $urandom};
            if (o == 2'b10 && ($urandom % 3) != 0) o = 2'b00;
            do_op(o, 2'($urandom % 4), a, d, "R1");
            if (($urandom % 10) == 0) clr_fault("R8");
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule